// File: doc/BRIEF.md
# SPI Flash Program/Erase Sequencer

This block is a host-side SPI master that turns high-level modify requests into the instruction frames a serial NOR flash expects. A request arrives on a valid/ready command port: program a run of bytes from a local buffer to a flash address, erase one sector, erase the whole chip, or write the status register. The caller must erase before programming, because programming can only clear bits. The sequencer never erases on its own.

Each request, and each page-sized piece of a program request, goes through the same fixed sequence of frames. A write-enable frame comes first, then a status read that confirms the enable latch is set. The command frame follows, and then repeated status reads until the busy flag clears. Every frame has its own chip-select assertion, separated from the next by a minimum idle time. The data to be programmed is read one byte at a time through an address/data port into a buffer that the caller fills beforehand. A single `done` pulse ends each request. `err` is raised with it when the enable check fails or the busy poll times out.

The FSM has these states: ST_IDLE, ST_GAP, ST_WREN, ST_WELCHK, ST_CMD, ST_POLL and ST_FINISH. The transitions are:
- accept: ST_IDLE to ST_GAP.
- empty: ST_IDLE to ST_FINISH, for a program request of zero length.
- resume: ST_GAP to the frame state that was queued.
- enabled: ST_WREN to ST_WELCHK.
- wel_ok: ST_WELCHK to ST_CMD.
- wel_bad: ST_WELCHK to ST_FINISH.
- issued: ST_CMD to ST_POLL.
- busy: ST_POLL to ST_POLL.
- next_page: ST_POLL to ST_WREN.
- ready: ST_POLL to ST_FINISH.
- timeout: ST_POLL to ST_FINISH.
- report: ST_FINISH to ST_IDLE.

Each of the paths into a frame state passes through ST_GAP.

Top module: `flash_seq`

## Requirements
- R1: `cmd_ready` is high only when the sequencer is idle, and a request is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_op` is encoded as 0 = program, 1 = sector erase, 2 = chip erase and 3 = status write. Each request ends with a one-cycle `done` pulse, and `cmd_ready` is high again on the following cycle.
- R2: The SPI link runs in mode 0.
  - `spi_sclk` is low whenever `spi_cs_n` is high.
  - Bytes go out most-significant bit first.
  - `spi_mosi` changes only while `spi_sclk` is low.
  - Every high level of `spi_sclk` lasts exactly CLK_HALF system cycles.
  - `spi_miso` is sampled on the rising edge of `spi_sclk`.
- R3: Every accepted request, and every page burst of a program request, opens with two frames. The first is a frame holding only the byte 06h. The second is a two-byte frame of 05h followed by one filler byte, which reads status back.
- R4: The sequencer checks bit 1 of the status byte read after the enable frame. If that bit is 0, it sends no further frame and finishes with `done` and `err` both high.
- R5: The command frames are as follows:
  - Sector erase is D8h followed by three address bytes, highest byte first.
  - Chip erase is C7h alone.
  - Status write is 01h followed by `cmd_sr`.
- R6: A program burst is 02h, then three address bytes with the highest byte first, then the data bytes. Data byte k of the request is read at `buf_addr` = k, counting from 0 across the whole request. The buffer must present `buf_data` in the same cycle as `buf_addr`.
- R7: No program burst crosses a 256-byte page boundary. A request that spans pages is split into page-bounded bursts at increasing addresses. Each burst has its own enable frame, enable check and busy poll.
- R8: After each command frame the sequencer repeats the two-byte status read until bit 0 reads 0. When the last burst is no longer busy, it finishes with `err` low.
- R9: If POLL_MAX status reads in a row all show bit 0 set, the sequencer stops polling and finishes with `done` and `err` both high, leaving `spi_cs_n` high.
- R10: `spi_cs_n` stays high for at least 4*CLK_HALF system cycles (two SPI clock periods) between frames.
- R11: A program request of length 0 finishes with `done` high and `err` low, and sends no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request can be taken |
| cmd_op | input | 2 | Operation: 0 program, 1 sector erase, 2 chip erase, 3 status write |
| cmd_addr | input | 24 | Flash byte address of the request |
| cmd_len | input | LEN_W | Program byte count |
| cmd_sr | input | 8 | Value for a status write |
| buf_addr | output | LEN_W | Offset of the data byte wanted from the local buffer |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request failed, valid with `done` |

## Verification
The bench builds the sequencer with CLK_HALF = 2, LEN_W = 10 and POLL_MAX = 6. With these values a 256-byte burst and requests of up to 300 bytes, split across as many as three pages, fit in a short run. A bench flash model is set to stay busy for longer than six reads. This lets the bench reach the poll timeout path, as well as the normal busy-then-ready sequences of zero to three busy reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int unsigned ADDR_W = 24;
    localparam int unsigned PAGE_W = 8;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_CHIP  = 2'd2,
        OP_WSTAT = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_WREN,
        ST_WELCHK,
        ST_CMD,
        ST_POLL,
        ST_FINISH
    } fst_e;

    localparam logic [7:0] INS_WREN = 8'h06;
    localparam logic [7:0] INS_RDSR = 8'h05;
    localparam logic [7:0] INS_PP   = 8'h02;
    localparam logic [7:0] INS_SE   = 8'hD8;
    localparam logic [7:0] INS_BE   = 8'hC7;
    localparam logic [7:0] INS_WRSR = 8'h01;

endpackage

// File: rtl/flash_byte_shift.sv
// One mode-0 byte transfer: MSB first, sample on rising, shift on falling.
module flash_byte_shift #(
    parameter int unsigned HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic [HW-1:0] hcnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            sh     <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx;
                hcnt   <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (hcnt == HW'(HALF - 1)) begin
                    hcnt <= '0;
                    sclk <= ~sclk;
                    if (!sclk) begin
                        rx <= {rx[6:0], miso};
                    end else begin
                        sh   <= {sh[6:0], 1'b0};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    hcnt <= hcnt + HW'(1);
                end
            end
        end
    end

    assign mosi = sh[7];

endmodule

// File: rtl/flash_gap_timer.sv
// Counts the chip-select idle time between frames.
module flash_gap_timer #(
    parameter int unsigned CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned W = $clog2(CYC + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= W'(CYC - 1);
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int unsigned CLK_HALF = 4,
    parameter int unsigned LEN_W    = 10,
    parameter int unsigned POLL_MAX = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [7:0]          cmd_sr,
    output logic [LEN_W-1:0]    buf_addr,
    input  logic [7:0]          buf_data,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                done,
    output logic                err
);
    localparam int unsigned GAP_CYC = 4 * CLK_HALF;
    localparam int unsigned PW      = $clog2(POLL_MAX + 1);
    localparam int unsigned BI_W    = PAGE_W + 2;

    fst_e              state, nxt, ret_st, nxt_ret;
    fop_e              op_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain, buf_ptr;
    logic [7:0]        sr_q, tx_byte, x_rx;
    logic [BI_W-1:0]   bidx, flen;
    logic [PW-1:0]     pcnt;
    logic [PAGE_W:0]   page_room, blen;
    logic              issued, err_q, x_start, x_done, gap_load, gap_exp;
    logic              last_byte, frame_end, set_err;

    flash_byte_shift #(.HALF(CLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(x_start), .tx(tx_byte), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(x_done), .rx(x_rx)
    );

    flash_gap_timer #(.CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_exp)
    );

    // Burst size: what is left, clipped at the end of the current page.
    always_comb begin
        page_room = (PAGE_W+1)'(1 << PAGE_W) - {1'b0, cur_addr[PAGE_W-1:0]};
        if ((LEN_W+1)'(remain) < (LEN_W+1)'(page_room)) blen = (PAGE_W+1)'(remain);
        else                                             blen = page_room;
    end

    // Frame length and the byte at the current position.
    always_comb begin
        flen    = BI_W'(1);
        tx_byte = 8'h00;
        unique case (state)
            ST_WREN: tx_byte = INS_WREN;
            ST_WELCHK, ST_POLL: begin
                flen    = BI_W'(2);
                tx_byte = (bidx == '0) ? INS_RDSR : 8'h00;
            end
            ST_CMD: begin
                unique case (op_q)
                    OP_PROG:  flen = BI_W'(4) + BI_W'(blen);
                    OP_SECT:  flen = BI_W'(4);
                    OP_CHIP:  flen = BI_W'(1);
                    OP_WSTAT: flen = BI_W'(2);
                    default:  flen = BI_W'(1);
                endcase
                if (bidx == BI_W'(0)) begin
                    unique case (op_q)
                        OP_PROG:  tx_byte = INS_PP;
                        OP_SECT:  tx_byte = INS_SE;
                        OP_CHIP:  tx_byte = INS_BE;
                        OP_WSTAT: tx_byte = INS_WRSR;
                        default:  tx_byte = INS_BE;
                    endcase
                end else if (bidx == BI_W'(1)) tx_byte = (op_q == OP_WSTAT) ? sr_q : cur_addr[23:16];
                else if (bidx == BI_W'(2))     tx_byte = cur_addr[15:8];
                else if (bidx == BI_W'(3))     tx_byte = cur_addr[7:0];
                else                           tx_byte = buf_data;
            end
            default: ;
        endcase
    end

    assign last_byte = (bidx == flen - BI_W'(1));
    assign frame_end = x_done && last_byte;

    // Next state and outputs.
    always_comb begin
        nxt       = state;
        nxt_ret   = ret_st;
        gap_load  = 1'b0;
        x_start   = 1'b0;
        set_err   = 1'b0;
        spi_cs_n  = 1'b1;
        cmd_ready = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    if (cmd_op == OP_PROG && cmd_len == '0) nxt = ST_FINISH;
                    else begin nxt = ST_GAP; nxt_ret = ST_WREN; gap_load = 1'b1; end
                end
            end
            ST_GAP: if (gap_exp) nxt = ret_st;
            ST_WREN, ST_WELCHK, ST_CMD, ST_POLL: begin
                spi_cs_n = 1'b0;
                x_start  = !issued;
                if (frame_end) begin
                    nxt      = ST_GAP;
                    gap_load = 1'b1;
                    unique case (state)
                        ST_WREN:   nxt_ret = ST_WELCHK;
                        ST_WELCHK: begin
                            nxt_ret = ST_CMD;
                            if (!x_rx[1]) begin nxt = ST_FINISH; gap_load = 1'b0; set_err = 1'b1; end
                        end
                        ST_CMD:    nxt_ret = ST_POLL;
                        default: begin
                            if (!x_rx[0]) begin
                                if (op_q == OP_PROG && remain != '0) nxt_ret = ST_WREN;
                                else begin nxt = ST_FINISH; gap_load = 1'b0; end
                            end else if (pcnt == PW'(POLL_MAX - 1)) begin
                                nxt = ST_FINISH; gap_load = 1'b0; set_err = 1'b1;
                            end else nxt_ret = ST_POLL;
                        end
                    endcase
                end
            end
            ST_FINISH: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign err      = done && err_q;
    assign buf_addr = buf_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ret_st   <= ST_WREN;
            op_q     <= OP_PROG;
            cur_addr <= '0;
            remain   <= '0;
            buf_ptr  <= '0;
            sr_q     <= '0;
            bidx     <= '0;
            pcnt     <= '0;
            issued   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (gap_load) ret_st <= nxt_ret;
            if (set_err)  err_q  <= 1'b1;
            if (state == ST_IDLE && cmd_valid) begin
                op_q     <= fop_e'(cmd_op);
                cur_addr <= cmd_addr;
                remain   <= cmd_len;
                sr_q     <= cmd_sr;
                buf_ptr  <= '0;
                err_q    <= 1'b0;
            end
            if (x_start) issued <= 1'b1;
            if (x_done) begin
                issued <= 1'b0;
                bidx   <= last_byte ? '0 : bidx + BI_W'(1);
                if (state == ST_CMD && op_q == OP_PROG && bidx >= BI_W'(4))
                    buf_ptr <= buf_ptr + LEN_W'(1);
            end
            if (state == ST_CMD && frame_end) begin
                pcnt <= '0;
                if (op_q == OP_PROG) begin
                    cur_addr <= cur_addr + ADDR_W'(blen);
                    remain   <= remain - LEN_W'(blen);
                end
            end
            if (state == ST_POLL && frame_end && x_rx[0]) pcnt <= pcnt + PW'(1);
        end
    end

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int unsigned CLK_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic done,
    input logic err
);
    localparam int unsigned GAP_CYC = 4 * CLK_HALF;

    logic        cs_prev, sclk_prev;
    logic [15:0] hi_cnt, lvl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
            hi_cnt    <= '0;
            lvl_cnt   <= '0;
        end else begin
            cs_prev   <= spi_cs_n;
            sclk_prev <= spi_sclk;
            if (!spi_cs_n)                hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF)  hi_cnt <= hi_cnt + 16'd1;
            if (spi_sclk != sclk_prev)     lvl_cnt <= '0;
            else if (lvl_cnt != 16'hFFFF) lvl_cnt <= lvl_cnt + 16'd1;
        end
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> spi_cs_n);
    p_done_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);
    p_sclk_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
    p_sclk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_sclk && sclk_prev) |-> (lvl_cnt == 16'(CLK_HALF - 1)));
    p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && cs_prev) |-> (hi_cnt >= 16'(GAP_CYC)));

endmodule

bind flash_seq flash_seq_chk #(.CLK_HALF(CLK_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .done(done), .err(err)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int HALF = 2;
    localparam int LW   = 10;
    localparam int PMAX = 6;
    localparam int GAP  = 4 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cmd_valid = 1'b0, cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [23:0]   cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [7:0]    cmd_sr = '0;
    logic [LW-1:0] buf_addr;
    logic [7:0]    buf_data;
    logic          spi_cs_n, spi_sclk, spi_mosi, done, err;
    logic          spi_miso = 1'b0;

    logic [7:0] bufmem [0:(1<<LW)-1];
    assign buf_data = bufmem[buf_addr];

    flash_seq #(.CLK_HALF(HALF), .LEN_W(LW), .POLL_MAX(PMAX)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_sr(cmd_sr),
        .buf_addr(buf_addr), .buf_data(buf_data), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .done(done), .err(err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit wd = 1'b0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) wd = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model and link monitors
    bit pcs = 1'b1, psclk = 1'b0, pmosi = 1'b0;
    int bitc = 0, bytec = 0, hi_len = 1000, sc_hi = 0;
    logic [7:0] shin = '0, outsh = '0, nextout = '0;
    bit wel = 1'b0, no_wel = 1'b0;
    int wip_left = 0, busy_cfg = 0, nfr = 0;
    int flen_log [0:63];
    logic [7:0] fb [0:63][0:263];
    int mon_sclk = 0, mon_mosi = 0, mon_idle = 0, mon_gap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sclk) mon_idle++;
            if (spi_sclk) sc_hi++;
            else begin
                if (psclk && sc_hi != HALF) mon_sclk++;
                sc_hi = 0;
            end
            if (!spi_cs_n && psclk && spi_sclk && spi_mosi !== pmosi) mon_mosi++;
            if (pcs && !spi_cs_n) begin
                if (hi_len < GAP) mon_gap++;
                bitc = 0; bytec = 0; outsh = 8'h00; nextout = 8'h00; spi_miso = 1'b0;
            end
            if (spi_cs_n) hi_len++; else hi_len = 0;
            if (!spi_cs_n && !psclk && spi_sclk) begin
                shin = {shin[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    if (nfr < 64 && bytec < 264) fb[nfr][bytec] = shin;
                    bytec++;
                    bitc = 0;
                    nextout = (bytec == 1 && shin == 8'h05) ? {6'b0, wel, (wip_left > 0)} : 8'h00;
                end
            end
            if (!spi_cs_n && psclk && !spi_sclk) begin
                if (bitc == 0) outsh = nextout;
                else outsh = {outsh[6:0], 1'b0};
                spi_miso = outsh[7];
            end
            if (!pcs && spi_cs_n) begin
                if (nfr < 64) begin
                    flen_log[nfr] = bytec;
                    if (bytec > 0) begin
                        case (fb[nfr][0])
                            8'h06: wel = !no_wel;
                            8'h05: if (wip_left > 0) wip_left--;
                            8'h02, 8'hD8, 8'hC7, 8'h01: if (wel) begin wip_left = busy_cfg; wel = 1'b0; end
                            default: ;
                        endcase
                    end
                end
                nfr++;
            end
            pcs = spi_cs_n; psclk = spi_sclk; pmosi = spi_mosi;
        end
    end

    task automatic cmp_frame(input int i, input logic [7:0] eb [0:263], input int el, input int ncmp,
                             input string req, input string what);
        bit ok = (i < 64) && (i < nfr);
        int bad = 0;
        if (ok && flen_log[i] != el) ok = 1'b0;
        for (int j = 0; j < ncmp; j++)
            if (ok && fb[i][j] !== eb[j]) begin ok = 1'b0; bad = j; end
        chk(ok, req, $sformatf("%s frame %0d byte %0d", what, i, bad),
            (i < 64) ? ((bad < 264) ? int'(fb[i][bad]) : 0) : -1, int'(eb[bad]));
    endtask

    task automatic run_op(input logic [1:0] op, input logic [23:0] addr, input int len,
                          input logic [7:0] sr, input int busy, input bit nowel);
        logic [7:0] eb [0:263];
        int idx = 0, rem = len, boff = 0, blen, npoll;
        logic [23:0] a = addr;
        bit to = (busy >= PMAX), exp_err, got_err, more = 1'b1;
        exp_err = nowel || to;
        no_wel = nowel; busy_cfg = busy; nfr = 0; wel = 1'b0; wip_left = 0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = LW'(len); cmd_sr = sr;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
        while (!done && !wd) @(negedge clk);
        got_err = err;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && spi_cs_n == 1'b1, "R1", "ready after done", cmd_ready, 1);
        if (!(op == 2'd0 && len == 0)) begin
            while (more) begin
                blen = 0;
                if (op == 2'd0) blen = (rem < 256 - int'(a[7:0])) ? rem : 256 - int'(a[7:0]);
                eb[0] = 8'h06;
                cmp_frame(idx, eb, 1, 1, "R3", "enable"); idx++;
                eb[0] = 8'h05;
                cmp_frame(idx, eb, 2, 1, "R3", "enable readback"); idx++;
                if (nowel) break;
                eb[1] = a[23:16]; eb[2] = a[15:8]; eb[3] = a[7:0];
                case (op)
                    2'd0: begin
                        eb[0] = 8'h02;
                        for (int j = 0; j < blen; j++) eb[4+j] = bufmem[boff+j];
                        cmp_frame(idx, eb, 4 + blen, 4 + blen, (len != blen) ? "R7" : "R6", "program");
                    end
                    2'd1: begin eb[0] = 8'hD8; cmp_frame(idx, eb, 4, 4, "R5", "sector"); end
                    2'd2: begin eb[0] = 8'hC7; cmp_frame(idx, eb, 1, 1, "R5", "chip"); end
                    default: begin eb[0] = 8'h01; eb[1] = sr; cmp_frame(idx, eb, 2, 2, "R5", "status write"); end
                endcase
                idx++;
                npoll = to ? PMAX : busy + 1;
                eb[0] = 8'h05;
                for (int k = 0; k < npoll; k++) begin
                    cmp_frame(idx, eb, 2, 1, to ? "R9" : "R8", "poll"); idx++;
                end
                if (to) break;
                rem -= blen; a += 24'(blen); boff += blen;
                more = (op == 2'd0 && rem > 0);
            end
        end
        chk(nfr == idx, (op == 2'd0 && len == 0) ? "R11" : "R7", "frame count", nfr, idx);
        chk(got_err == exp_err, nowel ? "R4" : (to ? "R9" : "R8"), "error flag", got_err, exp_err);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << LW); i++) bufmem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && done == 1'b0, "R2", "reset pins", {spi_cs_n, spi_sclk, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);

        run_op(2'd2, 24'h000000, 0, 8'h00, 2, 1'b0);        // R5 chip erase
        run_op(2'd1, 24'h123456, 0, 8'h00, 0, 1'b0);        // R5 sector
        run_op(2'd3, 24'h000000, 0, 8'h3C, 1, 1'b0);        // R5 status write
        run_op(2'd0, 24'h000010, 5, 8'h00, 1, 1'b0);        // R6
        run_op(2'd0, 24'h0000F0, 40, 8'h00, 0, 1'b0);       // R7 split 16+24
        run_op(2'd0, 24'h000100, 256, 8'h00, 0, 1'b0);      // R7 full page
        run_op(2'd0, 24'h0001FF, 2, 8'h00, 0, 1'b0);        // R7 one byte per page
        run_op(2'd0, 24'h000040, 0, 8'h00, 0, 1'b0);        // R11
        run_op(2'd0, 24'h000000, 8, 8'h00, 0, 1'b1);        // R4
        run_op(2'd1, 24'h0A0000, 0, 8'h00, 1000, 1'b0);     // R9
        for (int n = 0; n < 8 && !wd; n++)
            run_op(2'($urandom_range(0, 3)), 24'($urandom), $urandom_range(1, 300),
                   8'($urandom), $urandom_range(0, 3), 1'b0);

        chk(mon_sclk == 0, "R2", "sclk high width violations", mon_sclk, 0);
        chk(mon_mosi == 0 && mon_idle == 0, "R2", "mosi/idle clock violations", mon_mosi + mon_idle, 0);
        chk(mon_gap == 0, "R10", "short chip-select gaps", mon_gap, 0);
        if (wd) chk(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule